// File: doc/BRIEF.md
# Video input clamp sequencer

This block steers the clamp switches in front of a composite video ADC. Its job is to bring an input with an unknown DC level to a point where the sync tips fall inside the converter's range, so that the line PLL can lock. It sees the extended-range ADC samples, the converter's underflow flag, a strobe on each horizontal sync leading edge, a strobe at each line end and the lock flag of the line PLL. From these it produces a low-reference clamp enable and a high-reference clamp enable, and it reports which recovery phase it is in.

Recovery climbs through four phases. The first is a hard park on the low reference. The second lifts the input with high-clamp kicks whenever underflow persists. The third places a low-clamp pulse at a fixed delay after the sync edge. The fourth places the low-clamp pulse just inside the sync tip, using PLL timing. From the third phase on, every line must contain at least one sample below mid-scale, or the sequencer starts again from the park phase. When clamping is done elsewhere in the system, a disable input silences both clamp outputs.

Top module: `vclamp_seq`

## Requirements
- R1: Phases are reported on `phase_o` as 0 = park, 1 = lift, 2 = track, 3 = locked. Reset leaves the block in park. In park, `clamp_lo` is high on every cycle, and the block moves to lift on the sixth line strobe (LOW_LINES) and not before.
- R2: In lift, `adc_uflow` held for UF_RUN+1 (31) consecutive samples starts a high-clamp kick. `clamp_hi` then goes high in the cycle after that 31st sample and stays high for KICK_W (8) cycles. A run of exactly 30 samples gives no kick.
- R3: Lift moves to track on the line strobe that completes LIFT_LINES (4) consecutive lines without a kick. A line that contains a kick restarts that count.
- R4: In track, a sync strobe in cycle k drives `clamp_lo` high for PULSE_W (54) cycles, starting in cycle k+1+TRACK_DELAY (27). In lift, the sync strobe drives no low clamp.
- R5: In track and locked, `adc_sample` (signed two's complement, SAMPLE_W+1 = 8 bits) strictly below -DEEP_MARGIN (-2) for 31 consecutive samples starts the same kick as R2. A value of -2 never counts, and `adc_uflow` plays no part in these phases.
- R6: In track and locked, a line strobe that closes a line with no sample strictly below mid-scale (64) returns the block to park. A sample of 63 satisfies the check and a sample of 64 does not. This check takes priority over the lock rules.
- R7: Track moves to locked in the cycle after `pll_lock` is seen high. In locked, a sync strobe in cycle k drives `clamp_lo` high for PULSE_W cycles, starting in cycle k+1+LOCK_DELAY (4).
- R8: In locked, `pll_lock` seen low (with no failing line strobe in the same cycle) returns the block to track in the next cycle.
- R9: While `clamp_dis` is high, `clamp_lo` and `clamp_hi` are both low in that same cycle, and phase sequencing continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_sample | input | SAMPLE_W+1 | Signed extended-range ADC sample; 0 is the low reference |
| adc_uflow | input | 1 | ADC underflow flag |
| hsync_edge | input | 1 | One-cycle strobe on the horizontal sync leading edge |
| line_strb | input | 1 | One-cycle strobe at the end of each line |
| pll_lock | input | 1 | Line PLL lock flag |
| clamp_dis | input | 1 | Forces both clamp outputs low |
| clamp_lo | output | 1 | Clamp to the low ADC reference |
| clamp_hi | output | 1 | Clamp to the high reference (kick) |
| phase_o | output | 2 | Current recovery phase |

## Verification
Each input has a fixed latency. Phase changes caused by a line strobe or by the lock flag show on `phase_o` one cycle after the strobe or lock sample. A kick starts one cycle after the 31st qualifying sample. A low-clamp pulse starts 1+delay cycles after the sync strobe. The disable acts in the same cycle. The bench records both clamp outputs in every cycle of a 100-cycle line, after the inputs have settled and before the next edge. It then compares each record against the exact window computed from these latencies, and reads the phase only after the closing strobe has been clocked in.

// File: rtl/vclamp_pkg.sv
package vclamp_pkg;

    typedef enum logic [1:0] {
        PH_PARK   = 2'd0,
        PH_LIFT   = 2'd1,
        PH_TRACK  = 2'd2,
        PH_LOCKED = 2'd3
    } phase_e;

    typedef struct packed {
        logic kick_seen;
        logic low_seen;
    } line_flags_t;

    function automatic logic is_tracking(input phase_e p);
        return (p == PH_TRACK) || (p == PH_LOCKED);
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vclamp_run.sv
module vclamp_run #(
    parameter int LIMIT = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    output logic fire
);
    localparam int CW = $clog2(LIMIT + 2);

    logic [CW-1:0] run_cnt;

    // Fires once per run, on the first sample beyond LIMIT consecutive ones.
    assign fire = cond && (run_cnt == CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (!cond) begin
            run_cnt <= '0;
        end else if (run_cnt != CW'(LIMIT + 1)) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/vclamp_pulse.sv
module vclamp_pulse #(
    parameter int MAX_DELAY = 27,
    parameter int WIDTH     = 54,
    localparam int DW       = $clog2(MAX_DELAY + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trig,
    input  logic [DW-1:0] delay,
    output logic          active
);
    localparam int CW = $clog2(MAX_DELAY + WIDTH + 1);

    logic [CW-1:0] cnt;

    assign active = (cnt != '0) && (cnt <= CW'(WIDTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (trig) begin
            cnt <= CW'(delay) + CW'(WIDTH);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/vclamp_fsm.sv
module vclamp_fsm
    import vclamp_pkg::*;
#(
    parameter int LOW_LINES  = 6,
    parameter int LIFT_LINES = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   line_strb,
    input  logic   pll_lock,
    input  logic   below_mid,
    input  logic   kick_fire,
    output phase_e phase
);
    localparam int LMAX = max_int(LOW_LINES, LIFT_LINES);
    localparam int CW   = $clog2(LMAX + 1);

    logic [CW-1:0] line_cnt;
    line_flags_t   flags;
    line_flags_t   nflags;

    always_comb begin
        nflags.low_seen  = flags.low_seen  | below_mid;
        nflags.kick_seen = flags.kick_seen | kick_fire;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_PARK;
            line_cnt <= '0;
            flags    <= '0;
        end else begin
            flags <= line_strb ? line_flags_t'('0) : nflags;
            case (phase)
                PH_PARK: begin
                    if (line_strb) begin
                        if (line_cnt == CW'(LOW_LINES - 1)) begin
                            phase    <= PH_LIFT;
                            line_cnt <= '0;
                        end else begin
                            line_cnt <= line_cnt + 1'b1;
                        end
                    end
                end
                PH_LIFT: begin
                    if (line_strb) begin
                        if (nflags.kick_seen) begin
                            line_cnt <= '0;
                        end else if (line_cnt == CW'(LIFT_LINES - 1)) begin
                            phase    <= PH_TRACK;
                            line_cnt <= '0;
                        end else begin
                            line_cnt <= line_cnt + 1'b1;
                        end
                    end
                end
                PH_TRACK: begin
                    if (line_strb && !nflags.low_seen) begin
                        phase    <= PH_PARK;
                        line_cnt <= '0;
                    end else if (pll_lock) begin
                        phase <= PH_LOCKED;
                    end
                end
                default: begin
                    if (line_strb && !nflags.low_seen) begin
                        phase    <= PH_PARK;
                        line_cnt <= '0;
                    end else if (!pll_lock) begin
                        phase <= PH_TRACK;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/vclamp_seq.sv
module vclamp_seq
    import vclamp_pkg::*;
#(
    parameter int SAMPLE_W    = 7,
    parameter int LOW_LINES   = 6,
    parameter int LIFT_LINES  = 4,
    parameter int UF_RUN      = 30,
    parameter int DEEP_MARGIN = 2,
    parameter int PULSE_W     = 54,
    parameter int TRACK_DELAY = 27,
    parameter int LOCK_DELAY  = 4,
    parameter int KICK_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic signed [SAMPLE_W:0] adc_sample,
    input  logic                  adc_uflow,
    input  logic                  hsync_edge,
    input  logic                  line_strb,
    input  logic                  pll_lock,
    input  logic                  clamp_dis,
    output logic                  clamp_lo,
    output logic                  clamp_hi,
    output logic [1:0]            phase_o
);
    localparam int MID_INT   = 2 ** (SAMPLE_W - 1);
    localparam int DEEP_INT  = -DEEP_MARGIN;
    localparam int MAX_DELAY = max_int(TRACK_DELAY, LOCK_DELAY);
    localparam int DW        = $clog2(MAX_DELAY + 2);

    phase_e        phase;
    logic          below_mid;
    logic          deep_under;
    logic          kick_cond;
    logic          kick_fire;
    logic          kick_active;
    logic          lo_trig;
    logic [DW-1:0] lo_delay;
    logic          lo_active;

    assign below_mid  = int'(adc_sample) < MID_INT;
    assign deep_under = int'(adc_sample) < DEEP_INT;

    always_comb begin
        case (phase)
            PH_LIFT:             kick_cond = adc_uflow;
            PH_TRACK, PH_LOCKED: kick_cond = deep_under;
            default:             kick_cond = 1'b0;
        endcase
    end

    vclamp_run #(.LIMIT(UF_RUN)) u_run (
        .clk  (clk),
        .rst  (rst),
        .cond (kick_cond),
        .fire (kick_fire)
    );

    vclamp_pulse #(.MAX_DELAY(0), .WIDTH(KICK_W)) u_kick (
        .clk    (clk),
        .rst    (rst),
        .trig   (kick_fire),
        .delay  (1'b0),
        .active (kick_active)
    );

    assign lo_trig  = hsync_edge && is_tracking(phase);
    assign lo_delay = (phase == PH_LOCKED) ? DW'(LOCK_DELAY) : DW'(TRACK_DELAY);

    vclamp_pulse #(.MAX_DELAY(MAX_DELAY), .WIDTH(PULSE_W)) u_lo (
        .clk    (clk),
        .rst    (rst),
        .trig   (lo_trig),
        .delay  (lo_delay),
        .active (lo_active)
    );

    vclamp_fsm #(.LOW_LINES(LOW_LINES), .LIFT_LINES(LIFT_LINES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .line_strb (line_strb),
        .pll_lock  (pll_lock),
        .below_mid (below_mid),
        .kick_fire (kick_fire),
        .phase     (phase)
    );

    assign clamp_lo = !clamp_dis && ((phase == PH_PARK) || lo_active);
    assign clamp_hi = !clamp_dis && kick_active;
    assign phase_o  = phase;
endmodule

// File: rtl/vclamp_seq_chk.sv
module vclamp_seq_chk #(
    parameter int SAMPLE_W    = 7,
    parameter int DEEP_MARGIN = 2
) (
    input logic                  clk,
    input logic                  rst,
    input logic signed [SAMPLE_W:0] adc_sample,
    input logic                  adc_uflow,
    input logic                  line_strb,
    input logic                  pll_lock,
    input logic                  clamp_dis,
    input logic                  clamp_lo,
    input logic                  clamp_hi,
    input logic [1:0]            phase_o
);
    AST_DIS_QUIET: assert property (@(posedge clk) disable iff (rst)
        clamp_dis |-> (!clamp_lo && !clamp_hi)); // R9

    AST_PARK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd0 && !line_strb) |=> (phase_o == 2'd0)); // R1

    AST_LIFT_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd1) |=> (phase_o == 2'd1 || phase_o == 2'd2)); // R3

    AST_NO_EARLY_LOCK: assert property (@(posedge clk) disable iff (rst)
        (phase_o != 2'd3 && !(phase_o == 2'd2 && pll_lock)) |=> (phase_o != 2'd3)); // R7

    AST_LOCK_DROP: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'd3 && !pll_lock && !line_strb) |=> (phase_o == 2'd2)); // R8

    AST_KICK_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ($rose(clamp_hi) && !$past(clamp_dis)) |->
            ($past(adc_uflow) || (int'($past(adc_sample)) < -DEEP_MARGIN))); // R2
endmodule

bind vclamp_seq vclamp_seq_chk #(
    .SAMPLE_W    (SAMPLE_W),
    .DEEP_MARGIN (DEEP_MARGIN)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .adc_sample (adc_sample),
    .adc_uflow  (adc_uflow),
    .line_strb  (line_strb),
    .pll_lock   (pll_lock),
    .clamp_dis  (clamp_dis),
    .clamp_lo   (clamp_lo),
    .clamp_hi   (clamp_hi),
    .phase_o    (phase_o)
);

// File: tb/vclamp_seq_tb.sv
module vclamp_seq_tb;
    localparam int LEN = 100;

    logic              clk = 1'b0;
    logic              rst;
    logic signed [7:0] adc_sample;
    logic              adc_uflow;
    logic              hsync_edge;
    logic              line_strb;
    logic              pll_lock;
    logic              clamp_dis;
    logic              clamp_lo;
    logic              clamp_hi;
    logic [1:0]        phase_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    bit lo_log [0:LEN-1];
    bit hi_log [0:LEN-1];

    always #10 clk = ~clk;

    vclamp_seq u_dut (
        .clk        (clk),
        .rst        (rst),
        .adc_sample (adc_sample),
        .adc_uflow  (adc_uflow),
        .hsync_edge (hsync_edge),
        .line_strb  (line_strb),
        .pll_lock   (pll_lock),
        .clamp_dis  (clamp_dis),
        .clamp_lo   (clamp_lo),
        .clamp_hi   (clamp_hi),
        .phase_o    (phase_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic chk_phase(input int exp, input string tag);
        chk(int'(phase_o) == exp, tag, "phase", int'(phase_o), exp);
    endtask

    // Expect the logged output high exactly in cycles from..to of the last line.
    task automatic chk_win(input bit use_hi, input int from, input int to, input string tag);
        int bad_c = -1;
        int act = 0;
        int exp = 0;
        for (int c = 0; c < LEN; c++) begin
            bit e = (c >= from) && (c <= to);
            bit g = use_hi ? hi_log[c] : lo_log[c];
            if (g != e && bad_c < 0) begin
                bad_c = c;
                act = int'(g);
                exp = int'(e);
            end
        end
        chk(bad_c < 0, tag, $sformatf("%s window cycle %0d", use_hi ? "clamp_hi" : "clamp_lo", bad_c),
            act, exp);
    endtask

    task automatic idle();
        hsync_edge = 1'b0;
        line_strb  = 1'b0;
        adc_sample = 8'sd100;
        adc_uflow  = 1'b0;
    endtask

    task automatic run_line(input int low_at, input int low_n, input int low_val,
                            input int uf_at, input int uf_n, input bit lock, input bit dis);
        for (int c = 0; c < LEN; c++) begin
            hsync_edge = (c == 0);
            line_strb  = (c == LEN - 1);
            adc_sample = (c >= low_at && c < low_at + low_n) ? 8'(low_val) : 8'sd100;
            adc_uflow  = (c >= uf_at && c < uf_at + uf_n);
            pll_lock   = lock;
            clamp_dis  = dis;
            #1;
            lo_log[c] = clamp_lo;
            hi_log[c] = clamp_hi;
            @(posedge clk);
            #1;
        end
        idle();
    endtask

    task automatic climb();
        for (int i = 0; i < 6; i++) run_line(20, 10, 10, 0, 0, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) run_line(20, 10, 10, 0, 0, 1'b0, 1'b0);
    endtask

    initial begin
        #(64'd100000 * 20);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        pll_lock = 1'b0;
        clamp_dis = 1'b0;
        idle();
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        // R1 reset state
        chk_phase(0, "R1");
        chk(clamp_lo == 1'b1, "R1", "reset clamp_lo", int'(clamp_lo), 1);
        chk(clamp_hi == 1'b0, "R1", "reset clamp_hi", int'(clamp_hi), 0);

        // R1 park for six lines; R9 disable on the third park line
        for (int i = 0; i < 6; i++) begin
            run_line(20, 10, 10, 10, 40, 1'b0, i == 2);
            if (i == 2) chk_win(1'b0, -1, -2, "R9");
            else        chk_win(1'b0, 0, LEN - 1, "R1");
            chk_phase(i < 5 ? 0 : 1, "R1");
        end

        // R2 kick in lift, R4 no low pulse in lift
        run_line(0, 0, 0, 10, 40, 1'b0, 1'b0);
        chk_win(1'b1, 41, 48, "R2");
        chk_win(1'b0, -1, -2, "R4");
        // R2 exactly 30 samples of underflow: no kick
        run_line(0, 0, 0, 10, 30, 1'b0, 1'b0);
        chk_win(1'b1, -1, -2, "R2");
        run_line(0, 0, 0, 0, 0, 1'b0, 1'b0);
        run_line(0, 0, 0, 0, 0, 1'b0, 1'b0);
        chk_phase(1, "R3");
        run_line(0, 0, 0, 0, 0, 1'b0, 1'b0);
        chk_phase(2, "R3");

        // R4 track pulse window
        run_line(5, 11, 10, 0, 0, 1'b0, 1'b0);
        chk_win(1'b0, 28, 81, "R4");
        chk_win(1'b1, -1, -2, "R4");
        chk_phase(2, "R4");
        // R5 deep underflow threshold
        run_line(10, 40, -2, 10, 40, 1'b0, 1'b0);
        chk_win(1'b1, -1, -2, "R5");
        run_line(10, 40, -3, 0, 0, 1'b0, 1'b0);
        chk_win(1'b1, 41, 48, "R5");
        chk_phase(2, "R5");

        // R6 midscale check boundary
        run_line(50, 1, 63, 0, 0, 1'b0, 1'b0);
        chk_phase(2, "R6");
        run_line(50, 1, 64, 0, 0, 1'b0, 1'b0);
        chk_phase(0, "R6");

        climb();
        chk_phase(2, "R3");

        // R7 lock entry and locked pulse window
        run_line(20, 10, 10, 0, 0, 1'b1, 1'b0);
        chk_phase(3, "R7");
        run_line(20, 10, 10, 0, 0, 1'b1, 1'b0);
        chk_win(1'b0, 5, 58, "R7");
        chk_phase(3, "R7");
        // R8 lock loss
        run_line(20, 10, 10, 0, 0, 1'b0, 1'b0);
        chk_phase(2, "R8");
        run_line(20, 10, 10, 0, 0, 1'b1, 1'b0);
        chk_phase(3, "R7");
        // R9 disable in locked phase with a deep kick pending
        run_line(10, 40, -3, 0, 0, 1'b1, 1'b1);
        chk_win(1'b0, -1, -2, "R9");
        chk_win(1'b1, -1, -2, "R9");
        chk_phase(3, "R9");
        // R6 failing line while locked
        run_line(0, 0, 0, 0, 0, 1'b1, 1'b0);
        chk_phase(0, "R6");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule